// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Multi-Bit Current-Steering DAC

This block turns each 5-bit code from a multi-bit sigma-delta modulator into an enable pattern for 32 unit current sources. It picks elements with data weighted averaging. A code of N switches on N neighbouring elements, starting at a rotating start index. The start index then moves forward by N, wrapping at 32. This spreads element mismatch evenly over time, because every unit source is used the same number of times in the long run.

The start index is the only state that steers the selection. It is stored three times. A majority vote of the three copies runs every cycle, and the voted value is written back into all three copies, so a single upset is masked and then cleared.

The same pattern goes out on two separately registered buses, one for the main converter and one for the redundant converter. A small two-state machine tracks whether a code arrived in the previous cycle:
- ST_IDLE to ST_ACTIVE is taken when a valid code is accepted.
- ST_ACTIVE to ST_IDLE is taken on a cycle with no valid code.
- Each state holds itself while its condition repeats.

In ST_IDLE every element is off.

Top module: `dwa_sel`

## Requirements
- R1: While reset is high and in the first cycle after it falls, both enable buses are all zero and the state machine is in ST_IDLE. The first accepted code after reset starts its window at element 0.
- R2: One clock after a code N is accepted, exactly N bits of each enable bus are set. Bit i of the bus drives element i.
- R3: The enabled bits form one contiguous run upward from the current start index. When the run passes element 31 it continues at element 0.
- R4: After each accepted code N, the start index becomes (index + N) mod 32. Each window therefore begins at the element just after the last element of the previous window.
- R5: The main and redundant enable buses are identical in every cycle.
- R6: One clock after a cycle with the valid input low, both buses are all zero.
- R7: Cycles with the valid input low leave the start index unchanged. The next window starts where it would have started without the gap.
- R8: An accepted code of 0 enables no element and leaves the start index unchanged.
- R9: A wrong value in any one of the three index copies changes neither the current window nor any later window. The corrupted copy is rewritten with the voted value at the next clock.
- R10: After any run of accepted codes whose sum is a multiple of 32, every element has been enabled the same number of times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | A code is present on `code` this cycle |
| code | input | 5 | Modulator output code, the number of elements to enable |
| en_main | output | 32 | Element enables for the main converter |
| en_red | output | 32 | Element enables for the redundant converter |

## Verification
The hardest case to reach from the ports is a single upset in one index copy, because the vote hides it by design. The bench overrides one copy with a wrong value across a clock edge while it also presents a code. It then checks that the window in that cycle and the window in the next cycle both start where the bench's own model says they should. The wrap-around and equal-usage properties are driven by code sequences whose sums cross element 31 several times and total exact multiples of 32.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } dwa_state_e;

    // Bitwise two-of-three vote
    function automatic logic [15:0] vote3(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input logic [15:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/dwa_ptr_tmr.sv
module dwa_ptr_tmr
    import dwa_pkg::*;
#(
    parameter int N_ELEM = 32,
    parameter int PTR_W  = $clog2(N_ELEM)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_en,
    input  logic [PTR_W-1:0] step,
    output logic [PTR_W-1:0] ptr_o
);

    localparam int SUM_W = PTR_W + 1;

    logic [PTR_W-1:0] copy_a, copy_b, copy_c;
    logic [PTR_W-1:0] voted;
    logic [SUM_W-1:0] sum_w;
    logic [PTR_W-1:0] wrapped;
    logic [PTR_W-1:0] nxt;
    logic [15:0]      vote_full;

    // Vote the three copies every cycle
    always_comb begin
        vote_full = vote3(16'(copy_a), 16'(copy_b), 16'(copy_c));
        voted     = vote_full[PTR_W-1:0];
    end

    // Add the step and wrap at the element count
    always_comb begin
        sum_w = {1'b0, voted} + {1'b0, step};
        if (sum_w >= SUM_W'(N_ELEM)) begin
            wrapped = PTR_W'(sum_w - SUM_W'(N_ELEM));
        end else begin
            wrapped = sum_w[PTR_W-1:0];
        end
        nxt = adv_en ? wrapped : voted;
    end

    // Write the next value into all copies, which also scrubs any upset
    always_ff @(posedge clk) begin
        if (rst) begin
            copy_a <= '0;
            copy_b <= '0;
            copy_c <= '0;
        end else begin
            copy_a <= nxt;
            copy_b <= nxt;
            copy_c <= nxt;
        end
    end

    assign ptr_o = voted;

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        $past(adv_en) |-> (int'(ptr_o) == ((int'($past(ptr_o)) + int'($past(step))) % N_ELEM))) // R4
        else $error("start index did not advance by the code");

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(adv_en) |-> $stable(ptr_o)) // R7
        else $error("start index moved without a valid code");

endmodule

// File: rtl/dwa_window.sv
module dwa_window #(
    parameter int N_ELEM = 32,
    parameter int PTR_W  = $clog2(N_ELEM)
) (
    input  logic [PTR_W-1:0]  base,
    input  logic [PTR_W-1:0]  count,
    output logic [N_ELEM-1:0] win_o
);

    localparam int DBL_W = 2 * N_ELEM;

    logic [N_ELEM-1:0] therm;
    logic [DBL_W-1:0]  shifted;

    // Thermometer of 'count' ones, then rotate it left by 'base'
    always_comb begin
        for (int i = 0; i < N_ELEM; i++) begin
            therm[i] = (i < int'(count));
        end
        shifted = {{N_ELEM{1'b0}}, therm} << base;
        win_o   = shifted[N_ELEM-1:0] | shifted[DBL_W-1:N_ELEM];
    end

endmodule

// File: rtl/dwa_sel.sv
module dwa_sel
    import dwa_pkg::*;
#(
    parameter int N_ELEM = 32,
    parameter int CODE_W = $clog2(N_ELEM)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code,
    output logic [N_ELEM-1:0] en_main,
    output logic [N_ELEM-1:0] en_red
);

    dwa_state_e        state_q, state_d;
    logic [CODE_W-1:0] ptr;
    logic [N_ELEM-1:0] win;
    logic [N_ELEM-1:0] win_main_q, win_red_q;

    dwa_ptr_tmr #(.N_ELEM(N_ELEM), .PTR_W(CODE_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .adv_en (code_valid),
        .step   (code),
        .ptr_o  (ptr)
    );

    dwa_window #(.N_ELEM(N_ELEM), .PTR_W(CODE_W)) u_win (
        .base  (ptr),
        .count (code),
        .win_o (win)
    );

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = code_valid ? ST_ACTIVE : ST_IDLE;
            ST_ACTIVE: state_d = code_valid ? ST_ACTIVE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and window registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            win_main_q <= '0;
            win_red_q  <= '0;
        end else begin
            state_q <= state_d;
            if (code_valid) begin
                win_main_q <= win;
                win_red_q  <= win;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ACTIVE: begin
                en_main = win_main_q;
                en_red  = win_red_q;
            end
            default: begin
                en_main = '0;
                en_red  = '0;
            end
        endcase
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (en_main == '0)) // R1
        else $error("enables not cleared by reset");

    AST_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
        $past(code_valid) |-> ($countones(en_main) == int'($past(code)))) // R2
        else $error("enable count differs from code");

    AST_MIRROR: assert property (@(posedge clk) disable iff (rst)
        en_main == en_red) // R5
        else $error("main and redundant buses differ");

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(code_valid) |-> (en_main == '0)) // R6
        else $error("elements enabled without a code");

endmodule

// File: tb/dwa_sel_tb.sv
module dwa_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_valid = 1'b0;
    logic [4:0]  code = '0;
    logic [31:0] en_main, en_red;

    int errors = 0;
    int checks = 0;
    int exp_ptr = 0;
    int usage [32];
    bit done = 0;

    always #5 clk = ~clk;

    dwa_sel dut_i (
        .clk(clk), .rst(rst), .code_valid(code_valid), .code(code),
        .en_main(en_main), .en_red(en_red)
    );

    function automatic logic [31:0] exp_win(input int p, input int n);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++) begin
            if (((i - p + 32) % 32) < n) w[i] = 1'b1;
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one code, then check both buses after the edge
    task automatic step_code(input int n, input string req);
        logic [31:0] e;
        code_valid = 1'b1;
        code = 5'(n);
        @(negedge clk);
        e = exp_win(exp_ptr, n);
        chk(en_main == e, req, en_main, e);
        chk(en_red == en_main, "R5", en_red, en_main);
        for (int i = 0; i < 32; i++) if (e[i]) usage[i]++;
        exp_ptr = (exp_ptr + n) % 32;
    endtask

    task automatic idle_cycle();
        code_valid = 1'b0;
        code = 5'd19;
        @(negedge clk);
        chk(en_main == '0, "R6", en_main, '0);
        chk(en_red == '0, "R6", en_red, '0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(en_main == '0 && en_red == '0, "R1", en_main, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(en_main == '0, "R1", en_main, '0);
        exp_ptr = 0;
        step_code(6, "R1");
    endtask

    task automatic t_sweep();
        step_code(1, "R2");
        step_code(12, "R2");
        step_code(31, "R3");
        step_code(4, "R4");
        step_code(27, "R3");
    endtask

    task automatic t_idle();
        step_code(9, "R4");
        idle_cycle();
        idle_cycle();
        step_code(14, "R7");
    endtask

    task automatic t_zero();
        step_code(0, "R8");
        step_code(5, "R8");
    endtask

    task automatic t_upset();
        code_valid = 1'b1;
        code = 5'd11;
        force dut_i.u_ptr.copy_b = 5'(exp_ptr ^ 21);
        @(negedge clk);
        release dut_i.u_ptr.copy_b;
        chk(en_main == exp_win(exp_ptr, 11), "R9", en_main, exp_win(exp_ptr, 11));
        exp_ptr = (exp_ptr + 11) % 32;
        step_code(23, "R9");
        force dut_i.u_ptr.copy_c = 5'(exp_ptr ^ 7);
        step_code(17, "R9");
        release dut_i.u_ptr.copy_c;
        step_code(8, "R9");
    endtask

    task automatic t_usage();
        int lo, hi;
        int seq [6] = '{9, 23, 30, 2, 19, 13};
        for (int i = 0; i < 32; i++) usage[i] = 0;
        foreach (seq[k]) step_code(seq[k], "R3");
        lo = usage[0];
        hi = usage[0];
        for (int i = 1; i < 32; i++) begin
            if (usage[i] < lo) lo = usage[i];
            if (usage[i] > hi) hi = usage[i];
        end
        chk(lo == hi && hi == 3, "R10", 32'(hi), 32'(lo));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep();
        t_idle();
        t_zero();
        t_upset();
        t_usage();
        idle_cycle();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule